// File: doc/BRIEF.md
# Multiplexed-Bus External SRAM Glue

This block connects a master whose bus multiplexes address and data onto one set of lines to an 8 KB asynchronous static RAM. The master puts the high address byte on dedicated lines for the whole bus cycle. The low address byte appears on the shared lines only during the first half of the cycle, while an address strobe is high. Later in the same cycle, data uses those same lines. The block holds the low address byte once the strobe drops. It joins that byte with the lower five bits of the high byte to form the 13-bit memory address.

The block decodes the top three address bits into a memory select for the window 0x4000–0x5FFF. It gates the select, the write strobe and the read strobe with the high phase of the bus clock E, so the memory is enabled only while the address and data are settled.

Data moves in both directions. On a write, the bus byte is driven to the memory pins. On a read, the memory byte is driven back onto the bus lines. The two drive enables are brought out so that tri-state buffers outside the block can resolve the shared wires. The low-byte holder is clocked by a fast system clock and is bypassed while the strobe is high, so that it behaves as a transparent latch.

Top module: `xbus_sram_glue`

## Requirements
- R1: After reset, with the address strobe low, the low byte of `mem_addr` is 0x00 and every memory strobe and drive enable is inactive.
- R2: While `bus_as` is high, `mem_addr[7:0]` equals `bus_ad_i` in the same cycle.
- R3: After `bus_as` falls, `mem_addr[7:0]` keeps the value that `bus_ad_i` had at the last clock edge with `bus_as` high. It holds even when `bus_ad_i` then changes to data.
- R4: `mem_ce_n` is low and `mem_ce` is high exactly when `bus_e` is high and `bus_hi[7:5]` equals 3'b010.
- R5: `mem_we_n` is low only when the block is selected and `bus_rw` is 0 (write). In that window `mem_dq_oe` is 1 and `mem_dq_o` equals `bus_ad_i`.
- R6: `mem_oe_n` is low only when the block is selected and `bus_rw` is 1 (read). In that window `bus_ad_oe` is 1 and `bus_ad_o` equals `mem_dq_i`.
- R7: `mem_addr` is `{bus_hi[4:0], latched low byte}`, so a written byte reads back from the same bus address.
- R8: An address outside 0x4000–0x5FFF asserts no strobe and no drive enable, and a write to it leaves the memory contents unchanged. This covers the window edges 0x3FFF and 0x6000 and the internal regions 0x0000–0x00FF, 0x1000–0x103F, 0xB600–0xB7FF and 0xE000–0xFFFF.
- R9: While `bus_e` is low, all strobes and drive enables are inactive, even for an address in the window.
- R10: `mem_we_n` and `mem_oe_n` are never low together, and `bus_ad_oe` and `mem_dq_oe` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock sampling the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_e | input | 1 | Bus phase clock, high in the data half of a cycle |
| bus_as | input | 1 | Address strobe, high while the low address is on the shared lines |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_hi | input | 8 | High address byte A15–A8 |
| bus_ad_i | input | 8 | Shared address/data lines as seen by the block |
| bus_ad_o | output | 8 | Read data to drive onto the shared lines |
| bus_ad_oe | output | 1 | Drive enable for `bus_ad_o` |
| mem_addr | output | 13 | Memory address |
| mem_ce_n | output | 1 | Active-low memory chip enable |
| mem_ce | output | 1 | Active-high memory chip enable |
| mem_we_n | output | 1 | Active-low memory write strobe |
| mem_oe_n | output | 1 | Active-low memory output enable |
| mem_dq_i | input | 8 | Data from the memory pins |
| mem_dq_o | output | 8 | Write data to the memory pins |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |

## Verification
The bench builds the block with its defaults: a 16-bit bus address, 8-bit data, a 13-bit memory address and window block 2. These values make the edges 0x3FFF/0x4000 and 0x5FFF/0x6000 and the four internal regions reachable as concrete bus addresses. With them, a small associative memory model in the bench can store writes and return reads through the block's own address and strobes. Random addresses outside the window, with a random direction, exercise the decode, and random read-back pairs inside the window exercise the address join.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;

    // Regions the host keeps for itself; the external window must not touch them
    localparam int unsigned RSV_COUNT = 4;

    function automatic int unsigned rsv_lo(input int unsigned idx);
        case (idx)
            0:       return 32'h0000;
            1:       return 32'h1000;
            2:       return 32'hB600;
            default: return 32'hE000;
        endcase
    endfunction

    function automatic int unsigned rsv_hi(input int unsigned idx);
        case (idx)
            0:       return 32'h00FF;
            1:       return 32'h103F;
            2:       return 32'hB7FF;
            default: return 32'hFFFF;
        endcase
    endfunction

    function automatic bit window_clashes(input int unsigned base,
                                          input int unsigned last);
        bit hit;
        hit = 1'b0;
        for (int unsigned i = 0; i < RSV_COUNT; i++) begin
            if (base <= rsv_hi(i) && last >= rsv_lo(i)) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/xbus_lo_latch.sv
`timescale 1ns/1ps
module xbus_lo_latch #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         as_i,
    input  logic [W-1:0] ad_i,
    output logic [W-1:0] lo_o
);

    typedef struct packed {
        logic [W-1:0] lo;
    } lat_state_t;

    lat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (as_i) begin
            st_d.lo = ad_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Transparent while the strobe is high, held copy otherwise
    assign lo_o = as_i ? ad_i : st_q.lo;

    // R3
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !as_i |=> (as_i || $stable(lo_o)));

endmodule

// File: rtl/xbus_win_decode.sv
`timescale 1ns/1ps
module xbus_win_decode #(
    parameter int unsigned            TAG_W = 3,
    parameter logic [TAG_W-1:0]       CODE  = 3'b010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             e_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic             sel_o
);

    logic hit;

    assign hit   = (tag_i == CODE);
    assign sel_o = hit & e_i;

    // R9
    sel_needs_e_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !e_i |-> !sel_o);

    // R8
    sel_needs_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_i != CODE) |-> !sel_o);

endmodule

// File: rtl/xbus_strobe_gen.sv
`timescale 1ns/1ps
module xbus_strobe_gen
    import xbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sel_i,
    input  logic      rw_i,
    output acc_kind_t kind_o,
    output logic      ce_n_o,
    output logic      ce_o,
    output logic      we_n_o,
    output logic      oe_n_o
);

    always_comb begin
        kind_o = ACC_IDLE;
        if (sel_i) begin
            kind_o = rw_i ? ACC_READ : ACC_WRITE;
        end
    end

    assign ce_n_o = ~sel_i;
    assign ce_o   = sel_i;
    assign we_n_o = ~(kind_o == ACC_WRITE);
    assign oe_n_o = ~(kind_o == ACC_READ);

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n_o && !oe_n_o));

    // R4
    ce_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_o == !ce_n_o);

    // R5
    we_in_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_o |-> (!ce_n_o && !rw_i));

    // R6
    oe_in_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_o |-> (!ce_n_o && rw_i));

endmodule

// File: rtl/xbus_data_path.sv
`timescale 1ns/1ps
module xbus_data_path
    import xbus_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  acc_kind_t    kind_i,
    input  logic [W-1:0] ad_i,
    input  logic [W-1:0] mem_dq_i,
    output logic [W-1:0] ad_o,
    output logic         ad_oe_o,
    output logic [W-1:0] mem_dq_o,
    output logic         mem_dq_oe_o
);

    assign ad_oe_o     = (kind_i == ACC_READ);
    assign mem_dq_oe_o = (kind_i == ACC_WRITE);
    assign ad_o        = mem_dq_i;
    assign mem_dq_o    = ad_i;

    // R10
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ad_oe_o && mem_dq_oe_o));

endmodule

// File: rtl/xbus_sram_glue.sv
`timescale 1ns/1ps
module xbus_sram_glue
    import xbus_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned MEM_AW    = 13,
    parameter int unsigned WIN_BLOCK = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_e,
    input  logic                        bus_as,
    input  logic                        bus_rw,
    input  logic [ADDR_W-DATA_W-1:0]    bus_hi,
    input  logic [DATA_W-1:0]           bus_ad_i,
    output logic [DATA_W-1:0]           bus_ad_o,
    output logic                        bus_ad_oe,
    output logic [MEM_AW-1:0]           mem_addr,
    output logic                        mem_ce_n,
    output logic                        mem_ce,
    output logic                        mem_we_n,
    output logic                        mem_oe_n,
    input  logic [DATA_W-1:0]           mem_dq_i,
    output logic [DATA_W-1:0]           mem_dq_o,
    output logic                        mem_dq_oe
);

    localparam int unsigned HI_W     = ADDR_W - DATA_W;
    localparam int unsigned TAG_W    = ADDR_W - MEM_AW;
    localparam int unsigned MHI_W    = MEM_AW - DATA_W;
    localparam logic [TAG_W-1:0] WIN_CODE = TAG_W'(WIN_BLOCK);
    localparam int unsigned WIN_BASE = WIN_BLOCK << MEM_AW;
    localparam int unsigned WIN_LAST = WIN_BASE + (1 << MEM_AW) - 1;
    localparam bit WIN_CLASH = window_clashes(WIN_BASE, WIN_LAST);

    if (WIN_CLASH) begin : g_window_clash
        $error("external window overlaps a reserved host region");
    end

    logic [DATA_W-1:0] lo_byte;
    logic              sel;
    acc_kind_t         kind;

    xbus_lo_latch #(.W(DATA_W)) u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .as_i  (bus_as),
        .ad_i  (bus_ad_i),
        .lo_o  (lo_byte)
    );

    xbus_win_decode #(.TAG_W(TAG_W), .CODE(WIN_CODE)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .e_i   (bus_e),
        .tag_i (bus_hi[HI_W-1 -: TAG_W]),
        .sel_o (sel)
    );

    xbus_strobe_gen u_stb (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel),
        .rw_i   (bus_rw),
        .kind_o (kind),
        .ce_n_o (mem_ce_n),
        .ce_o   (mem_ce),
        .we_n_o (mem_we_n),
        .oe_n_o (mem_oe_n)
    );

    xbus_data_path #(.W(DATA_W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .kind_i      (kind),
        .ad_i        (bus_ad_i),
        .mem_dq_i    (mem_dq_i),
        .ad_o        (bus_ad_o),
        .ad_oe_o     (bus_ad_oe),
        .mem_dq_o    (mem_dq_o),
        .mem_dq_oe_o (mem_dq_oe)
    );

    assign mem_addr = {bus_hi[MHI_W-1:0], lo_byte};

    // R9
    quiet_low_e_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_e |-> (mem_ce_n && mem_we_n && mem_oe_n && !bus_ad_oe && !mem_dq_oe));

    // R8
    quiet_off_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hi[HI_W-1 -: TAG_W] != WIN_CODE) |->
            (mem_ce_n && mem_we_n && mem_oe_n && !bus_ad_oe && !mem_dq_oe));

    // R7
    addr_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> (mem_addr[MEM_AW-1 -: MHI_W] == bus_hi[MHI_W-1:0]));

endmodule

// File: tb/tb_xbus_sram_glue.sv
`timescale 1ns/1ps
module tb_xbus_sram_glue;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_e = 1'b0;
    logic        bus_as = 1'b0;
    logic        bus_rw = 1'b1;
    logic [7:0]  bus_hi = 8'h00;
    logic [7:0]  bus_ad_i = 8'h00;
    logic [7:0]  bus_ad_o;
    logic        bus_ad_oe;
    logic [12:0] mem_addr;
    logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n;
    logic [7:0]  mem_dq_i = 8'h00;
    logic [7:0]  mem_dq_o;
    logic        mem_dq_oe;

    always #5 clk = ~clk;

    xbus_sram_glue dut (
        .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_as(bus_as), .bus_rw(bus_rw),
        .bus_hi(bus_hi), .bus_ad_i(bus_ad_i), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_i(mem_dq_i), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
    );

    // strobe vector: {ce_n, ce, we_n, oe_n, ad_oe, dq_oe}
    localparam logic [5:0] S_IDLE  = 6'b101100;
    localparam logic [5:0] S_READ  = 6'b011010;
    localparam logic [5:0] S_WRITE = 6'b010101;

    typedef struct {
        string      req_s;
        logic [5:0] strb;
        string      req_a;
        logic [12:0] addr;
        string      req_d;
        bit         chk_ad;
        logic [7:0] ad;
        bit         chk_dq;
        logic [7:0] dq;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    int checks = 0;
    int failures = 0;
    logic [7:0] sram [int];
    logic [7:0] ref_mem [int];

    function automatic logic [7:0] sram_rd(input logic [12:0] a);
        if (sram.exists(int'(a))) return sram[int'(a)];
        return 8'hFF;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // SRAM model: write captured while the write strobe is low
    always @(negedge clk) begin
        if (rst_n && !mem_we_n && !mem_ce_n) sram[int'(mem_addr)] = mem_dq_o;
    end

    // Monitor: pops one expectation per cycle and compares at the falling edge
    always begin
        @(negedge clk);
        if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            check({mem_ce_n, mem_ce, mem_we_n, mem_oe_n, bus_ad_oe, mem_dq_oe} == cur.strb,
                  cur.req_s, "strobes",
                  int'({mem_ce_n, mem_ce, mem_we_n, mem_oe_n, bus_ad_oe, mem_dq_oe}),
                  int'(cur.strb));
            check(mem_addr == cur.addr, cur.req_a, "mem_addr", int'(mem_addr), int'(cur.addr));
            if (cur.chk_ad)
                check(bus_ad_o == cur.ad, cur.req_d, "bus_ad_o", int'(bus_ad_o), int'(cur.ad));
            if (cur.chk_dq)
                check(mem_dq_o == cur.dq, cur.req_d, "mem_dq_o", int'(mem_dq_o), int'(cur.dq));
        end
    end

    task automatic step(input logic e, input logic as_v, input logic rw,
                        input logic [7:0] hi, input logic [7:0] ad, input exp_t x);
        @(posedge clk);
        #2;
        bus_e = e; bus_as = as_v; bus_rw = rw; bus_hi = hi; bus_ad_i = ad;
        #1;
        mem_dq_i = (!mem_oe_n) ? sram_rd(mem_addr) : 8'hA5;
        exp_q.push_back(x);
    endtask

    task automatic bus_cycle(input logic [15:0] addr, input logic rw,
                             input logic [7:0] wdata, input logic [7:0] rexp);
        exp_t x;
        bit win;
        win = (addr[15:13] == 3'b010);
        x.addr = addr[12:0];
        x.chk_ad = 1'b0; x.chk_dq = 1'b0; x.ad = 8'h00; x.dq = 8'h00; x.req_d = "";
        // address phase
        x.strb = S_IDLE; x.req_s = "R9"; x.req_a = "R2";
        step(1'b0, 1'b1, rw, addr[15:8], addr[7:0], x);
        // strobe dropped, shared lines change
        x.req_a = "R3";
        step(1'b0, 1'b0, rw, addr[15:8], rw ? ~addr[7:0] : wdata, x);
        // data phase
        x.req_a = "R7";
        if (win) begin
            x.strb  = rw ? S_READ : S_WRITE;
            x.req_s = rw ? "R4/R6/R10" : "R4/R5/R10";
            x.req_d = rw ? "R6" : "R5";
            x.chk_ad = rw;  x.ad = rexp;
            x.chk_dq = !rw; x.dq = wdata;
        end else begin
            x.strb = S_IDLE; x.req_s = "R8";
        end
        step(1'b1, 1'b0, rw, addr[15:8], rw ? ~addr[7:0] : wdata, x);
        // cycle end
        x.strb = S_IDLE; x.req_s = "R9"; x.chk_ad = 1'b0; x.chk_dq = 1'b0;
        x.req_a = "R3";
        step(1'b0, 1'b0, rw, addr[15:8], 8'h00, x);
        if (win && !rw) ref_mem[int'(addr[12:0])] = wdata;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus_cycle(a, 1'b0, d, 8'h00);
    endtask

    task automatic rd(input logic [15:0] a);
        logic [7:0] e;
        e = ref_mem.exists(int'(a[12:0])) ? ref_mem[int'(a[12:0])] : 8'hFF;
        bus_cycle(a, 1'b1, 8'h00, e);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        exp_t x;
        logic [15:0] a;
        logic [15:0] rsv [8];
        rsv = '{16'h0000, 16'h00FF, 16'h1000, 16'h103F, 16'hB600, 16'hB7FF, 16'hE000, 16'hFFFF};

        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: reset state of the held byte
        x.strb = S_IDLE; x.req_s = "R1"; x.addr = 13'h0000; x.req_a = "R1";
        x.chk_ad = 1'b0; x.chk_dq = 1'b0; x.ad = 8'h00; x.dq = 8'h00; x.req_d = "";
        step(1'b0, 1'b0, 1'b1, 8'h00, 8'h77, x);

        // R5 / R7: writes at window edges and inside
        wr(16'h4000, 8'h5A);
        wr(16'h5FFF, 8'hC3);
        wr(16'h4ABC, 8'h11);
        wr(16'h5123, 8'hEE);
        // R6 / R7: read back
        rd(16'h4000);
        rd(16'h5FFF);
        rd(16'h4ABC);
        rd(16'h5123);

        // R8: edges just outside the window; writes there must not land
        wr(16'h3FFF, 8'h99);
        wr(16'h6000, 8'h98);
        rd(16'h3FFF);
        rd(16'h6000);
        rd(16'h5FFF);
        rd(16'h4000);

        // R8: internal regions, both directions
        foreach (rsv[i]) begin
            wr(rsv[i], 8'h42);
            rd(rsv[i]);
        end
        rd(16'h5FFF);

        // R8: random out-of-window traffic
        for (int i = 0; i < 40; i++) begin
            do a = 16'($urandom_range(0, 65535)); while (a[15:13] == 3'b010);
            bus_cycle(a, 1'($urandom_range(0, 1)), 8'($urandom), 8'h00);
        end
        rd(16'h4ABC);

        // R7: random in-window write / read-back pairs
        for (int i = 0; i < 24; i++) begin
            a = {3'b010, 13'($urandom)};
            wr(a, 8'($urandom));
            rd(a);
        end

        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule